// File: doc/BRIEF.md
# Table Transfer Unit

This block moves single bytes between a byte-addressed program memory and an 8-bit register interface. It keeps a 22-bit table pointer, loaded by software one byte at a time into three byte slots (upper, high and low), and an 8-bit transfer latch. A table-read command fetches the byte that the pointer selects through a simple synchronous memory port and places it in the latch. A table-write command copies the latch into one of eight holding bytes. Each command carries one of four pointer-update modes.

Pointer bit 21 selects the configuration and identification space rather than main memory. The increment and decrement modes touch only bits 20:0, which wrap within themselves. The block also produces the two aligned block addresses that outside controllers need. A long write takes the 8-byte block selected by bits 21:3 and receives all eight holding bytes in parallel. An erase takes the 64-byte block selected by bits 21:6. Each of these is announced with a one-cycle strobe. The block does not run the long write or the erase itself.

Commands, register writes and block starts are plain control pins and are not handshaked. While a read is in flight, `busy` is high and any such input is dropped. Software polls `busy` or watches `done` before it issues the next command.

Top module: `tbx_unit`

## Requirements
- R1: After reset the pointer, the latch and all eight holding bytes read as zero, and `busy`, `done`, `mem_rd_en`, `lw_strobe` and `erase_strobe` are low.
- R2: A register write with `sfr_sel` 0 loads pointer bits 7:0, 1 loads bits 15:8, 2 loads bits 21:16 from the six low data bits with the two upper data bits dropped, and 3 loads the latch. The other pointer bits are kept.
- R3: `cmd_mode` 0 leaves the pointer unchanged, 1 increments it after the access, 2 decrements it after the access, and 3 increments it before the access. Modes 0 to 2 access the old pointer. Mode 3 accesses the incremented pointer and keeps it.
- R4: Increment and decrement change only pointer bits 20:0, modulo 2^21. Bit 21 changes only through a register write.
- R5: An accepted read (`cmd_op`=0) drives `mem_rd_en` for exactly the next cycle, with `mem_addr` equal to all 22 bits of the access address. The memory returns data one cycle after `mem_rd_en`. In the second cycle after `mem_rd_en`, `done` is high, the latch holds the returned byte and the pointer holds its updated value.
- R6: While `busy` is high, commands, register writes, `lw_start` and `erase_start` are ignored.
- R7: An accepted write (`cmd_op`=1) copies the latch into the holding byte indexed by access-address bits 2:0 and updates the pointer. `done` is high in the next cycle and `busy` stays low.
- R8: `lw_start` produces a one-cycle `lw_strobe` in the next cycle, with `lw_addr` equal to pointer bits 21:3. `lw_data` always carries holding byte i on bits 8i+7:8i.
- R9: `erase_start` produces a one-cycle `erase_strobe` in the next cycle, with `erase_addr` equal to pointer bits 21:6.
- R10: `done` is a single-cycle pulse.
- R11: When a command is accepted in a cycle that also carries a register write, the register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_wr_en | input | 1 | Register write strobe |
| sfr_sel | input | 2 | Register select: 0 low, 1 high, 2 upper, 3 latch |
| sfr_wdata | input | 8 | Register write data |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 1 | 0 read, 1 write |
| cmd_mode | input | 2 | Pointer-update mode |
| lw_start | input | 1 | Long-write start request |
| erase_start | input | 1 | Erase start request |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_rd_en` |
| ptr_o | output | 22 | Current pointer |
| latch_o | output | 8 | Current latch |
| busy | output | 1 | Read in flight |
| done | output | 1 | Command completion pulse |
| mem_rd_en | output | 1 | Memory read enable |
| mem_addr | output | 22 | Memory byte address |
| lw_strobe | output | 1 | Long-write start pulse |
| lw_addr | output | 19 | 8-byte block address |
| lw_data | output | 64 | Eight holding bytes |
| erase_strobe | output | 1 | Erase start pulse |
| erase_addr | output | 16 | 64-byte block address |

## Verification
The bench builds the block with its default parameters: a 22-bit pointer, eight holding bytes and 64-byte erase blocks. Because the pointer is loaded directly through the byte registers, the 21-bit wrap in both directions and the bit-21 configuration space are reached in a few cycles, without stepping through the address range. The memory model returns a byte computed from the whole address, bit 21 included, so a dropped or misplaced address bit shows up in the latch.

// File: rtl/tbx_pkg.sv
package tbx_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD     = 2'd0,
    UPD_POST_INC = 2'd1,
    UPD_POST_DEC = 2'd2,
    UPD_PRE_INC  = 2'd3
  } upd_mode_e;

  typedef enum logic [1:0] {
    SEL_LO    = 2'd0,
    SEL_HI    = 2'd1,
    SEL_UP    = 2'd2,
    SEL_LATCH = 2'd3
  } sfr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/tbx_step.sv
module tbx_step
  import tbx_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  upd_mode_e        mode_i,
  output logic [PTR_W-1:0] acc_addr_o,
  output logic [PTR_W-1:0] next_ptr_o
);
  localparam int LOW_W = PTR_W - 1;

  logic [LOW_W-1:0] lo_inc;
  logic [LOW_W-1:0] lo_dec;

  // bit 21 is never carried into: the low field wraps on its own
  assign lo_inc = ptr_i[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1};
  assign lo_dec = ptr_i[LOW_W-1:0] - {{(LOW_W-1){1'b0}}, 1'b1};

  always_comb begin
    acc_addr_o = ptr_i;
    next_ptr_o = ptr_i;
    case (mode_i)
      UPD_HOLD:     next_ptr_o = ptr_i;
      UPD_POST_INC: next_ptr_o = {ptr_i[PTR_W-1], lo_inc};
      UPD_POST_DEC: next_ptr_o = {ptr_i[PTR_W-1], lo_dec};
      UPD_PRE_INC: begin
        next_ptr_o = {ptr_i[PTR_W-1], lo_inc};
        acc_addr_o = {ptr_i[PTR_W-1], lo_inc};
      end
      default:      next_ptr_o = ptr_i;
    endcase
  end
endmodule

// File: rtl/tbx_ptr.sv
module tbx_ptr
  import tbx_pkg::*;
#(
  parameter int PTR_W  = 22,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  sfr_sel_e          ld_sel,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              upd_en,
  input  logic [PTR_W-1:0]  upd_val,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int UP_W = PTR_W - 2 * BYTE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o <= '0;
    end else if (upd_en) begin
      ptr_o <= upd_val;
    end else if (ld_en) begin
      case (ld_sel)
        SEL_LO:  ptr_o[BYTE_W-1:0]          <= ld_byte;
        SEL_HI:  ptr_o[2*BYTE_W-1:BYTE_W]   <= ld_byte;
        SEL_UP:  ptr_o[PTR_W-1:2*BYTE_W]    <= ld_byte[UP_W-1:0];
        default: ptr_o                      <= ptr_o;
      endcase
    end
  end
endmodule

// File: rtl/tbx_hold.sv
module tbx_hold #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [W-1:0]         wr_data,
  output logic [N*W-1:0]       bytes_o
);
  localparam int IDX_W = $clog2(N);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_q <= wr_data;
      end
    end
    assign bytes_o[g*W +: W] = slot_q;
  end
endmodule

// File: rtl/tbx_unit.sv
module tbx_unit
  import tbx_pkg::*;
#(
  parameter int PTR_W       = 22,
  parameter int DATA_W      = 8,
  parameter int HOLD_N      = 8,
  parameter int ERASE_BYTES = 64,
  localparam int HOLD_IDX_W = $clog2(HOLD_N),
  localparam int ERASE_LSB  = $clog2(ERASE_BYTES),
  localparam int LW_AW      = PTR_W - HOLD_IDX_W,
  localparam int ER_AW      = PTR_W - ERASE_LSB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sfr_wr_en,
  input  logic [1:0]               sfr_sel,
  input  logic [DATA_W-1:0]        sfr_wdata,
  input  logic                     cmd_valid,
  input  logic                     cmd_op,
  input  logic [1:0]               cmd_mode,
  input  logic                     lw_start,
  input  logic                     erase_start,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [PTR_W-1:0]         ptr_o,
  output logic [DATA_W-1:0]        latch_o,
  output logic                     busy,
  output logic                     done,
  output logic                     mem_rd_en,
  output logic [PTR_W-1:0]         mem_addr,
  output logic                     lw_strobe,
  output logic [LW_AW-1:0]         lw_addr,
  output logic [HOLD_N*DATA_W-1:0] lw_data,
  output logic                     erase_strobe,
  output logic [ER_AW-1:0]         erase_addr
);
  rd_state_e         st_q;
  logic [PTR_W-1:0]  rd_addr_q;
  logic [PTR_W-1:0]  rd_next_q;
  logic [DATA_W-1:0] latch_q;
  logic              done_q;
  logic              lw_stb_q;
  logic [LW_AW-1:0]  lw_addr_q;
  logic              er_stb_q;
  logic [ER_AW-1:0]  er_addr_q;

  logic              accept;
  logic              acc_rd;
  logic              acc_wr;
  logic              sfr_ok;
  logic              rd_finish;
  logic [PTR_W-1:0]  acc_addr;
  logic [PTR_W-1:0]  next_ptr;
  logic              ptr_upd_en;
  logic [PTR_W-1:0]  ptr_upd_val;

  assign busy      = (st_q != ST_IDLE);
  assign accept    = cmd_valid && !busy;
  assign acc_rd    = accept && !cmd_op;
  assign acc_wr    = accept && cmd_op;
  assign sfr_ok    = sfr_wr_en && !busy && !accept;
  assign rd_finish = (st_q == ST_WAIT);

  tbx_step #(.PTR_W(PTR_W)) u_step (
    .ptr_i      (ptr_o),
    .mode_i     (upd_mode_e'(cmd_mode)),
    .acc_addr_o (acc_addr),
    .next_ptr_o (next_ptr)
  );

  // a read stores its pointer update when the byte lands; a write stores at once
  assign ptr_upd_en  = acc_wr || rd_finish;
  assign ptr_upd_val = rd_finish ? rd_next_q : next_ptr;

  tbx_ptr #(.PTR_W(PTR_W), .BYTE_W(DATA_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (sfr_ok && (sfr_sel_e'(sfr_sel) != SEL_LATCH)),
    .ld_sel  (sfr_sel_e'(sfr_sel)),
    .ld_byte (sfr_wdata),
    .upd_en  (ptr_upd_en),
    .upd_val (ptr_upd_val),
    .ptr_o   (ptr_o)
  );

  tbx_hold #(.N(HOLD_N), .W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_wr),
    .wr_idx  (acc_addr[HOLD_IDX_W-1:0]),
    .wr_data (latch_q),
    .bytes_o (lw_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rd_addr_q <= '0;
      rd_next_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (acc_rd) begin
          rd_addr_q <= acc_addr;
          rd_next_q <= next_ptr;
          st_q      <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= acc_wr || rd_finish;
      if (rd_finish) begin
        latch_q <= mem_rdata;
      end else if (sfr_ok && (sfr_sel_e'(sfr_sel) == SEL_LATCH)) begin
        latch_q <= sfr_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lw_stb_q  <= 1'b0;
      lw_addr_q <= '0;
      er_stb_q  <= 1'b0;
      er_addr_q <= '0;
    end else begin
      lw_stb_q <= lw_start && !busy;
      er_stb_q <= erase_start && !busy;
      if (lw_start && !busy) lw_addr_q <= ptr_o[PTR_W-1:HOLD_IDX_W];
      if (erase_start && !busy) er_addr_q <= ptr_o[PTR_W-1:ERASE_LSB];
    end
  end

  assign latch_o      = latch_q;
  assign done         = done_q;
  assign mem_rd_en    = (st_q == ST_ISSUE);
  assign mem_addr     = rd_addr_q;
  assign lw_strobe    = lw_stb_q;
  assign lw_addr      = lw_addr_q;
  assign erase_strobe = er_stb_q;
  assign erase_addr   = er_addr_q;
endmodule

// File: rtl/tbx_checker.sv
module tbx_checker #(
  parameter int PTR_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sfr_wr_en,
  input logic [PTR_W-1:0] ptr_o,
  input logic             busy,
  input logic             done,
  input logic             mem_rd_en,
  input logic [PTR_W-1:0] mem_addr,
  input logic             lw_strobe,
  input logic             erase_strobe
);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R5
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ##1 done);

  // R5
  rd_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[PTR_W-1] == ptr_o[PTR_W-1]));

  // R4
  top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_wr_en |=> $stable(ptr_o[PTR_W-1]));

  // R6
  busy_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> $stable(ptr_o));

  // R8
  lw_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lw_strobe |=> !lw_strobe);

  // R9
  er_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_strobe |=> !erase_strobe);

  // R6
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);
endmodule

bind tbx_unit tbx_checker #(.PTR_W(PTR_W)) u_tbx_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sfr_wr_en    (sfr_wr_en),
  .ptr_o        (ptr_o),
  .busy         (busy),
  .done         (done),
  .mem_rd_en    (mem_rd_en),
  .mem_addr     (mem_addr),
  .lw_strobe    (lw_strobe),
  .erase_strobe (erase_strobe)
);

// File: tb/tbx_unit_bench.sv
module tbx_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr_en = 1'b0;
  logic [1:0]  sfr_sel = 2'd0;
  logic [7:0]  sfr_wdata = 8'd0;
  logic        cmd_valid = 1'b0;
  logic        cmd_op = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        lw_start = 1'b0;
  logic        erase_start = 1'b0;
  logic [7:0]  mem_rdata;
  logic [21:0] ptr_o;
  logic [7:0]  latch_o;
  logic        busy;
  logic        done;
  logic        mem_rd_en;
  logic [21:0] mem_addr;
  logic        lw_strobe;
  logic [18:0] lw_addr;
  logic [63:0] lw_data;
  logic        erase_strobe;
  logic [15:0] erase_addr;

  int compared = 0;
  int mismatched = 0;
  logic finished = 1'b0;
  logic [63:0] shadow_hold = '0;

  always #10 clk = ~clk;

  tbx_unit u_tbx_unit (
    .clk(clk), .rst_n(rst_n), .sfr_wr_en(sfr_wr_en), .sfr_sel(sfr_sel),
    .sfr_wdata(sfr_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mode(cmd_mode), .lw_start(lw_start), .erase_start(erase_start),
    .mem_rdata(mem_rdata), .ptr_o(ptr_o), .latch_o(latch_o), .busy(busy),
    .done(done), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .lw_strobe(lw_strobe), .lw_addr(lw_addr), .lw_data(lw_data),
    .erase_strobe(erase_strobe), .erase_addr(erase_addr)
  );

  function automatic logic [7:0] memf(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ (a[21] ? 8'h5A : 8'h00);
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= memf(mem_addr);
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    sfr_wr_en = 1'b1; sfr_sel = sel; sfr_wdata = d;
    @(negedge clk);
    sfr_wr_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] p);
    sfr_write(2'd0, p[7:0]);
    sfr_write(2'd1, p[15:8]);
    sfr_write(2'd2, {2'b00, p[21:16]});
  endtask

  task automatic do_read(input logic [1:0] mode, input logic [21:0] exp_addr,
                         input logic [21:0] exp_ptr, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_mode = mode;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({"R5 rd_en ", req}, mem_rd_en, 1'b1);
    check({"R3 addr ", req}, mem_addr, exp_addr);
    @(negedge clk);
    @(negedge clk);
    check({"R5 done ", req}, done, 1'b1);
    check({"R5 latch ", req}, latch_o, memf(exp_addr));
    check({"R4 ptr ", req}, ptr_o, exp_ptr);
    @(negedge clk);
    check({"R10 done pulse ", req}, done, 1'b0);
  endtask

  task automatic do_write(input logic [1:0] mode, input logic [2:0] idx,
                          input logic [21:0] exp_ptr);
    shadow_hold[idx*8 +: 8] = latch_o;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_mode = mode;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R7 write done", done, 1'b1);
    check("R7 write not busy", busy, 1'b0);
    check("R7 write ptr", ptr_o, exp_ptr);
    check("R7 holding bytes", lw_data, shadow_hold);
  endtask

  task automatic t_reset();
    check("R1 ptr", ptr_o, 22'd0);
    check("R1 latch", latch_o, 8'd0);
    check("R1 hold", lw_data, 64'd0);
    check("R1 flags", {busy, done, mem_rd_en, lw_strobe, erase_strobe}, 5'd0);
  endtask

  task automatic t_sfr();
    set_ptr(22'h12_3456);
    check("R2 three bytes", ptr_o, 22'h12_3456);
    sfr_write(2'd2, 8'hFF);
    check("R2 upper drops top bits", ptr_o, 22'h3F_3456);
    sfr_write(2'd0, 8'hA1);
    check("R2 low only", ptr_o, 22'h3F_34A1);
    sfr_write(2'd3, 8'hC3);
    check("R2 latch", {latch_o, ptr_o}, {8'hC3, 22'h3F_34A1});
  endtask

  task automatic t_read_modes();
    set_ptr(22'h12_3456);
    do_read(2'd0, 22'h12_3456, 22'h12_3456, "R3 hold");
    do_read(2'd1, 22'h12_3456, 22'h12_3457, "R3 post-inc");
    do_read(2'd2, 22'h12_3457, 22'h12_3456, "R3 post-dec");
    do_read(2'd3, 22'h12_3457, 22'h12_3457, "R3 pre-inc");
  endtask

  task automatic t_wrap();
    set_ptr(22'h1F_FFFF);
    do_read(2'd1, 22'h1F_FFFF, 22'h00_0000, "R4 wrap up low space");
    set_ptr(22'h3F_FFFF);
    do_read(2'd1, 22'h3F_FFFF, 22'h20_0000, "R4 wrap up keeps bit21");
    do_read(2'd2, 22'h20_0000, 22'h3F_FFFF, "R4 wrap down keeps bit21");
    set_ptr(22'h3F_FFFF);
    do_read(2'd3, 22'h20_0000, 22'h20_0000, "R4 pre-inc wrap");
  endtask

  task automatic t_writes();
    set_ptr(22'h00_0100);
    for (int i = 0; i < 8; i++) begin
      sfr_write(2'd3, 8'h11 + 8'(i));
      do_write(2'd1, 3'(i), 22'h00_0101 + 22'(i));
    end
    sfr_write(2'd3, 8'hE7);
    do_write(2'd3, 3'd1, 22'h00_0109);
    sfr_write(2'd3, 8'h3C);
    do_write(2'd2, 3'd1, 22'h00_0108);
    sfr_write(2'd3, 8'h4D);
    do_write(2'd0, 3'd0, 22'h00_0108);
  endtask

  task automatic t_blocks();
    set_ptr(22'h2A_BCDF);
    @(negedge clk);
    lw_start = 1'b1;
    @(negedge clk);
    lw_start = 1'b0;
    check("R8 lw strobe", lw_strobe, 1'b1);
    check("R8 lw addr", lw_addr, 19'(22'h2A_BCDF >> 3));
    check("R8 lw data", lw_data, shadow_hold);
    @(negedge clk);
    check("R8 lw strobe single", lw_strobe, 1'b0);
    erase_start = 1'b1;
    @(negedge clk);
    erase_start = 1'b0;
    check("R9 erase strobe", erase_strobe, 1'b1);
    check("R9 erase addr", erase_addr, 16'(22'h2A_BCDF >> 6));
    @(negedge clk);
    check("R9 erase strobe single", erase_strobe, 1'b0);
  endtask

  task automatic t_busy();
    set_ptr(22'h00_0050);
    sfr_write(2'd3, 8'h66);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b0; cmd_mode = 2'd1;
    @(negedge clk);
    check("R6 read issued", mem_rd_en, 1'b1);
    cmd_op = 1'b1; cmd_mode = 2'd3;
    sfr_wr_en = 1'b1; sfr_sel = 2'd0; sfr_wdata = 8'hEE;
    lw_start = 1'b1; erase_start = 1'b1;
    @(negedge clk);
    check("R6 no strobes while busy", {lw_strobe, erase_strobe}, 2'b00);
    @(negedge clk);
    cmd_valid = 1'b0; sfr_wr_en = 1'b0; lw_start = 1'b0; erase_start = 1'b0;
    check("R6 read done", done, 1'b1);
    check("R6 ptr untouched", ptr_o, 22'h00_0051);
    check("R6 latch from memory", latch_o, memf(22'h00_0050));
    check("R6 hold untouched", lw_data, shadow_hold);
    check("R6 no late strobes", {lw_strobe, erase_strobe}, 2'b00);
    @(negedge clk);
  endtask

  task automatic t_collide();
    set_ptr(22'h00_0020);
    sfr_write(2'd3, 8'h77);
    shadow_hold[7:0] = 8'h77;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 1'b1; cmd_mode = 2'd1;
    sfr_wr_en = 1'b1; sfr_sel = 2'd0; sfr_wdata = 8'h99;
    @(negedge clk);
    cmd_valid = 1'b0; sfr_wr_en = 1'b0;
    check("R11 sfr dropped", ptr_o, 22'h00_0021);
    check("R11 write landed", lw_data, shadow_hold);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sfr();
    t_read_modes();
    t_wrap();
    t_writes();
    t_blocks();
    t_busy();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule